// File: doc/BRIEF.md
# SDRAM Write Burst Engine

This block is the device-side write path of a single-data-rate SDRAM with four banks and a 16-bit data bus. It watches the command pins on each rising clock edge and recognises a WRITE. The DQ value presented together with that command is the first data beat. Every following edge brings one more beat, until the burst is complete, is cut short by a newer WRITE, or, in full-page mode, runs on without end. Each accepted beat leaves the block as one array write strobe, with the bank, row, column and data for that beat.

The burst length comes from a static setting input, and the open row of each bank comes from a packed per-bank input. Address bit 10, sampled with the command, asks for auto-precharge. A burst that runs to its natural end with that bit set raises a single-cycle precharge request for its bank. A burst that another WRITE cuts short never raises one. Holding clock enable low freezes the burst where it stands. All outputs are registered, so the strobe for a beat appears one cycle after the edge that captured it.

Top module: `sdram_wr_burst`

## Requirements
- R1: A WRITE is the pin state cs_n=0, ras_n=1, cas_n=0, we_n=0 sampled with cke=1. One cycle after it, aw_en is 1 with aw_col = a[9:0], aw_bank = ba, aw_data = the dq value sampled with the command, and aw_row = bits [13*b+12 : 13*b] of open_row, where b is that bank.
- R2: Each later cycle of the burst gives one more array write, with the dq value of that cycle. The column steps up by one and wraps inside the aligned block of the burst length.
- R3: bl_sel is sampled with the WRITE and sets the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. Any other code is treated as 1 beat.
- R4: Once a fixed-length burst has produced its last beat, aw_en stays 0 and dq is ignored until the next WRITE.
- R5: A full-page burst never ends by itself. It passes from column 1023 to column 0 and keeps going.
- R6: A WRITE on any cycle, including the cycle right after another WRITE, ends the current burst at once. The dq value that comes with it is the first beat of the new burst.
- R7: With a[10]=1 on the WRITE, the array write of the burst's last beat comes with pre_req, which is one-hot on bit ba and lasts one cycle. With a[10]=0, pre_req stays 0.
- R8: A burst that a new WRITE cuts short raises no pre_req for its bank, even if a[10] was 1. A full-page burst is always cut short in this way.
- R9: While cke=0, no array write is produced, the command pins are ignored, and the burst position is held. When cke returns to 1, the burst resumes at the next column.
- R10: A pin state other than WRITE, including any state with cs_n=1, neither starts nor stops a burst.
- R11: While rst_n is low, aw_en=0, pre_req=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the write path |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write enable pin |
| a | input | 13 | Address pins: column in [9:0], auto-precharge flag in [10] |
| ba | input | 2 | Bank address |
| dq | input | 16 | Write data |
| bl_sel | input | 3 | Burst length code |
| open_row | input | 52 | Open row of each bank, 13 bits per bank, bank 0 in the low bits |
| aw_en | output | 1 | Array write strobe |
| aw_bank | output | 2 | Bank of the array write |
| aw_row | output | 13 | Row of the array write |
| aw_col | output | 10 | Column of the array write |
| aw_data | output | 16 | Data of the array write |
| pre_req | output | 4 | Per-bank precharge request pulse |

## Verification
The hardest case to reach from the ports is the precharge decision when two events meet. One is a burst that would have reached its last beat in the very cycle a new WRITE arrives. The other is a run of WRITEs on consecutive cycles, each of which must replace the previous burst's length, bank and auto-precharge flag. The stimulus table places commands on adjacent cycles. It starts an eight-beat burst with auto-precharge, cuts it off after two beats with a one-beat burst that completes at once, and follows that straight away with a further WRITE. This checks that only the completed bursts raise a request. The full-page case starts two columns below the page end, so the wrap shows within a few beats, and then truncates the burst.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  // Burst length codes on bl_sel
  localparam logic [2:0] BL_ONE   = 3'b000;
  localparam logic [2:0] BL_TWO   = 3'b001;
  localparam logic [2:0] BL_FOUR  = 3'b010;
  localparam logic [2:0] BL_EIGHT = 3'b011;
  localparam logic [2:0] BL_PAGE  = 3'b111;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_OTHER = 2'd2
  } cmd_e;

endpackage

// File: rtl/sdram_wr_rst_sync.sv
module sdram_wr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/sdram_wr_cmd_dec.sv
module sdram_wr_cmd_dec
  import sdram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] a,
  input  logic [2:0]        bl_sel,
  output cmd_e              cmd,
  output logic              cmd_ap,
  output logic [COL_W-1:0]  cmd_col,
  output logic [COL_W-1:0]  cmd_mask,
  output logic              cmd_full
);

  logic unused_abits;
  assign unused_abits = ^a[ADDR_W-1:AP_BIT+1];

  always_comb begin
    if (!cke || cs_n) begin
      cmd = CMD_IDLE;
    end else if (ras_n && !cas_n && !we_n) begin
      cmd = CMD_WRITE;
    end else begin
      cmd = CMD_OTHER;
    end
  end

  assign cmd_ap  = a[AP_BIT];
  assign cmd_col = a[COL_W-1:0];

  always_comb begin
    cmd_full = 1'b0;
    cmd_mask = '0;
    unique case (bl_sel)
      BL_TWO:   cmd_mask = COL_W'(1);
      BL_FOUR:  cmd_mask = COL_W'(3);
      BL_EIGHT: cmd_mask = COL_W'(7);
      BL_PAGE: begin
        cmd_mask = '1;
        cmd_full = 1'b1;
      end
      default:  cmd_mask = '0;
    endcase
  end

endmodule

// File: rtl/sdram_wr_col_seq.sv
module sdram_wr_col_seq #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] col,
  input  logic [COL_W-1:0] mask,
  output logic [COL_W-1:0] col_nx
);

  logic [COL_W-1:0] col_inc;

  assign col_inc = col + COL_W'(1);

  // Per bit: bits inside the burst block take the incremented value,
  // bits above it keep the block base.
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_nx[i] = mask[i] ? col_inc[i] : col[i];
  end

endmodule

// File: rtl/sdram_wr_burst_ctrl.sv
module sdram_wr_burst_ctrl #(
  parameter int COL_W  = 10,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 16,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              wr_cmd,
  input  logic              cmd_ap,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [COL_W-1:0]  cmd_mask,
  input  logic              cmd_full,
  input  logic [DQ_W-1:0]   dq,
  output logic              aw_en,
  output logic [BANK_W-1:0] aw_bank,
  output logic [ROW_W-1:0]  aw_row,
  output logic [COL_W-1:0]  aw_col,
  output logic [DQ_W-1:0]   aw_data,
  output logic [NB-1:0]     pre_req
);

  logic              act_q,  act_n;
  logic              ap_q,   ap_n;
  logic              full_q, full_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [ROW_W-1:0]  row_q,  row_n;
  logic [COL_W-1:0]  col_q,  col_n;
  logic [COL_W-1:0]  mask_q, mask_n;
  logic [COL_W-1:0]  left_q, left_n;
  logic              wen_q,  wen_n;
  logic [NB-1:0]     pre_q,  pre_n;
  logic [DQ_W-1:0]   dat_q;
  logic [COL_W-1:0]  col_step;
  logic              burst_en;

  sdram_wr_col_seq #(.COL_W(COL_W)) u_col_seq (
    .col    (col_q),
    .mask   (mask_q),
    .col_nx (col_step)
  );

  // Next-state logic
  always_comb begin
    act_n  = act_q;
    ap_n   = ap_q;
    full_n = full_q;
    bank_n = bank_q;
    row_n  = row_q;
    col_n  = col_q;
    mask_n = mask_q;
    left_n = left_q;
    wen_n  = 1'b0;
    pre_n  = '0;
    if (cke) begin
      if (wr_cmd) begin
        bank_n = cmd_bank;
        row_n  = cmd_row;
        col_n  = cmd_col;
        mask_n = cmd_mask;
        full_n = cmd_full;
        ap_n   = cmd_ap;
        left_n = cmd_mask;
        act_n  = cmd_full || (cmd_mask != '0);
        wen_n  = 1'b1;
        if (!cmd_full && (cmd_mask == '0) && cmd_ap) begin
          pre_n[cmd_bank] = 1'b1;
        end
      end else if (act_q) begin
        col_n = col_step;
        wen_n = 1'b1;
        if (!full_q) begin
          left_n = left_q - COL_W'(1);
          if (left_q == COL_W'(1)) begin
            act_n = 1'b0;
            if (ap_q) begin
              pre_n[bank_q] = 1'b1;
            end
          end
        end
      end
    end
  end

  assign burst_en = cke && (wr_cmd || act_q);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ap_q   <= 1'b0;
      full_q <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      mask_q <= '0;
      left_q <= '0;
      wen_q  <= 1'b0;
      pre_q  <= '0;
    end else begin
      act_q  <= act_n;
      ap_q   <= ap_n;
      full_q <= full_n;
      bank_q <= bank_n;
      row_q  <= row_n;
      col_q  <= col_n;
      mask_q <= mask_n;
      left_q <= left_n;
      wen_q  <= wen_n;
      pre_q  <= pre_n;
    end
  end

  // Data capture register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (burst_en) begin
      dat_q <= dq;
    end
  end

  assign aw_en   = wen_q;
  assign aw_bank = bank_q;
  assign aw_row  = row_q;
  assign aw_col  = col_q;
  assign aw_data = dat_q;
  assign pre_req = pre_q;

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst
  import sdram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 16,
  parameter int AP_BIT = 10,
  localparam int NB    = 1 << BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   a,
  input  logic [BANK_W-1:0]   ba,
  input  logic [DQ_W-1:0]     dq,
  input  logic [2:0]          bl_sel,
  input  logic [NB*ROW_W-1:0] open_row,
  output logic                aw_en,
  output logic [BANK_W-1:0]   aw_bank,
  output logic [ROW_W-1:0]    aw_row,
  output logic [COL_W-1:0]    aw_col,
  output logic [DQ_W-1:0]     aw_data,
  output logic [NB-1:0]       pre_req
);

  logic              srst_n;
  cmd_e              cmd;
  logic              cmd_ap;
  logic              cmd_full;
  logic [COL_W-1:0]  cmd_col;
  logic [COL_W-1:0]  cmd_mask;
  logic [ROW_W-1:0]  bank_row [NB];
  logic [ROW_W-1:0]  sel_row;
  logic              wr_cmd;

  sdram_wr_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sdram_wr_cmd_dec #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) u_cmd_dec (
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a        (a),
    .bl_sel   (bl_sel),
    .cmd      (cmd),
    .cmd_ap   (cmd_ap),
    .cmd_col  (cmd_col),
    .cmd_mask (cmd_mask),
    .cmd_full (cmd_full)
  );

  for (genvar b = 0; b < NB; b++) begin : g_row
    assign bank_row[b] = open_row[b*ROW_W +: ROW_W];
  end

  assign sel_row = bank_row[ba];
  assign wr_cmd  = (cmd == CMD_WRITE);

  sdram_wr_burst_ctrl #(
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W),
    .DQ_W   (DQ_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .cke      (cke),
    .wr_cmd   (wr_cmd),
    .cmd_ap   (cmd_ap),
    .cmd_bank (ba),
    .cmd_row  (sel_row),
    .cmd_col  (cmd_col),
    .cmd_mask (cmd_mask),
    .cmd_full (cmd_full),
    .dq       (dq),
    .aw_en    (aw_en),
    .aw_bank  (aw_bank),
    .aw_row   (aw_row),
    .aw_col   (aw_col),
    .aw_data  (aw_data),
    .pre_req  (pre_req)
  );

endmodule

// File: rtl/sdram_wr_burst_chk.sv
module sdram_wr_burst_chk #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 16,
  localparam int NB    = 1 << BANK_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cke,
  input logic                cs_n,
  input logic                ras_n,
  input logic                cas_n,
  input logic                we_n,
  input logic [ADDR_W-1:0]   a,
  input logic [BANK_W-1:0]   ba,
  input logic [DQ_W-1:0]     dq,
  input logic [NB*ROW_W-1:0] open_row,
  input logic                aw_en,
  input logic [BANK_W-1:0]   aw_bank,
  input logic [ROW_W-1:0]    aw_row,
  input logic [COL_W-1:0]    aw_col,
  input logic [DQ_W-1:0]     aw_data,
  input logic [NB-1:0]       pre_req
);

  logic pin_wr;
  assign pin_wr = cke && !cs_n && ras_n && !cas_n && !we_n;

  AST_CMD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pin_wr |=> (aw_en && aw_col == $past(a[COL_W-1:0]) && aw_bank == $past(ba)
                && aw_data == $past(dq))) else $error("cmd beat mismatch"); // R1

  AST_CMD_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    pin_wr |=> (aw_row == $past(open_row[int'(ba)*ROW_W +: ROW_W])))
    else $error("row mismatch"); // R1

  AST_PRE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pre_req)) else $error("precharge not one-hot"); // R7

  AST_PRE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_req != '0) |-> (aw_en && pre_req[aw_bank])) else $error("precharge without beat"); // R7

  AST_CKE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (!aw_en && pre_req == '0 && $stable(aw_col))) else $error("activity with cke low"); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!aw_en && pre_req == '0)) else $error("outputs active in reset"); // R11

endmodule

bind sdram_wr_burst sdram_wr_burst_chk #(
  .ADDR_W (ADDR_W),
  .COL_W  (COL_W),
  .ROW_W  (ROW_W),
  .BANK_W (BANK_W),
  .DQ_W   (DQ_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cke      (cke),
  .cs_n     (cs_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .a        (a),
  .ba       (ba),
  .dq       (dq),
  .open_row (open_row),
  .aw_en    (aw_en),
  .aw_bank  (aw_bank),
  .aw_row   (aw_row),
  .aw_col   (aw_col),
  .aw_data  (aw_data),
  .pre_req  (pre_req)
);

// File: tb/sdram_wr_burst_tb.sv
`timescale 1ns/1ps
module sdram_wr_burst_tb;

  logic        clk;
  logic        rst_n;
  logic        cke;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [12:0] a;
  logic [1:0]  ba;
  logic [15:0] dq;
  logic [2:0]  bl_sel;
  logic [51:0] open_row;
  logic        aw_en;
  logic [1:0]  aw_bank;
  logic [12:0] aw_row;
  logic [9:0]  aw_col;
  logic [15:0] aw_data;
  logic [3:0]  pre_req;

  int n_chk;
  int n_err;
  bit done;

  sdram_wr_burst u_dut (
    .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .a (a), .ba (ba), .dq (dq), .bl_sel (bl_sel),
    .open_row (open_row), .aw_en (aw_en), .aw_bank (aw_bank), .aw_row (aw_row),
    .aw_col (aw_col), .aw_data (aw_data), .pre_req (pre_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [12:0] row_of(input logic [1:0] b);
    return 13'h100 + 13'(b);
  endfunction

  typedef struct packed {
    logic        wr;
    logic        ap;
    logic [1:0]  bk;
    logic [9:0]  col;
    logic [15:0] dq;
    logic [2:0]  bl;
    logic        en;
    logic [1:0]  ebk;
    logic [9:0]  ecol;
    logic [15:0] edat;
    logic [3:0]  epre;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    // R1 R2 R3 R7: 4-beat burst from column 5, auto-precharge on bank 1
    '{1'b1,1'b1,2'd1,10'd5,   16'hA000,3'd2, 1'b1,2'd1,10'd5,   16'hA000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hA001,3'd0, 1'b1,2'd1,10'd6,   16'hA001,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hA002,3'd0, 1'b1,2'd1,10'd7,   16'hA002,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hA003,3'd0, 1'b1,2'd1,10'd4,   16'hA003,4'h2},
    // R4: data after burst end ignored
    '{1'b0,1'b0,2'd0,10'd0,   16'hA004,3'd0, 1'b0,2'd0,10'd0,   16'h0000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hA005,3'd0, 1'b0,2'd0,10'd0,   16'h0000,4'h0},
    // R2 R3 R7: 2-beat burst from column 9, no auto-precharge
    '{1'b1,1'b0,2'd2,10'd9,   16'hB000,3'd1, 1'b1,2'd2,10'd9,   16'hB000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hB001,3'd0, 1'b1,2'd2,10'd8,   16'hB001,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hB002,3'd0, 1'b0,2'd0,10'd0,   16'h0000,4'h0},
    // R6 R8: 8-beat burst with auto-precharge cut after two beats
    '{1'b1,1'b1,2'd3,10'd0,   16'hC000,3'd3, 1'b1,2'd3,10'd0,   16'hC000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hC001,3'd0, 1'b1,2'd3,10'd1,   16'hC001,4'h0},
    '{1'b1,1'b1,2'd0,10'd20,  16'hD000,3'd0, 1'b1,2'd0,10'd20,  16'hD000,4'h1},
    '{1'b1,1'b0,2'd1,10'd30,  16'hE000,3'd0, 1'b1,2'd1,10'd30,  16'hE000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hE001,3'd0, 1'b0,2'd0,10'd0,   16'h0000,4'h0},
    // R2: 8-beat burst from column 6 wraps inside block 0..7
    '{1'b1,1'b0,2'd0,10'd6,   16'hF000,3'd3, 1'b1,2'd0,10'd6,   16'hF000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF001,3'd0, 1'b1,2'd0,10'd7,   16'hF001,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF002,3'd0, 1'b1,2'd0,10'd0,   16'hF002,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF003,3'd0, 1'b1,2'd0,10'd1,   16'hF003,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF004,3'd0, 1'b1,2'd0,10'd2,   16'hF004,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF005,3'd0, 1'b1,2'd0,10'd3,   16'hF005,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF006,3'd0, 1'b1,2'd0,10'd4,   16'hF006,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF007,3'd0, 1'b1,2'd0,10'd5,   16'hF007,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'hF008,3'd0, 1'b0,2'd0,10'd0,   16'h0000,4'h0},
    // R5 R8: full page from 1022 wraps to 0, then truncated
    '{1'b1,1'b1,2'd2,10'd1022,16'h1000,3'd7, 1'b1,2'd2,10'd1022,16'h1000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'h1001,3'd0, 1'b1,2'd2,10'd1023,16'h1001,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'h1002,3'd0, 1'b1,2'd2,10'd0,   16'h1002,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'h1003,3'd0, 1'b1,2'd2,10'd1,   16'h1003,4'h0},
    '{1'b1,1'b0,2'd2,10'd100, 16'h2000,3'd0, 1'b1,2'd2,10'd100, 16'h2000,4'h0},
    '{1'b0,1'b0,2'd0,10'd0,   16'h2001,3'd0, 1'b0,2'd0,10'd0,   16'h0000,4'h0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_nop(input logic [15:0] d);
    cke = 1'b1; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    a = '0; ba = '0; dq = d; bl_sel = 3'd0;
  endtask

  task automatic drive_wr(input logic ap, input logic [1:0] b, input logic [9:0] c,
                          input logic [15:0] d, input logic [2:0] bl);
    cke = 1'b1; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b0;
    a = {2'b00, ap, c}; ba = b; dq = d; bl_sel = bl;
  endtask

  task automatic expect_beat(input string req, input logic [1:0] b,
                             input logic [9:0] c, input logic [15:0] d,
                             input logic [3:0] p);
    check(aw_en == 1'b1, req, 32'(aw_en), 32'd1);
    check(aw_col == c, req, 32'(aw_col), 32'(c));
    check(aw_data == d, req, 32'(aw_data), 32'(d));
    check(aw_bank == b, req, 32'(aw_bank), 32'(b));
    check(aw_row == row_of(b), req, 32'(aw_row), 32'(row_of(b)));
    check(pre_req == p, req, 32'(pre_req), 32'(p));
  endtask

  task automatic expect_idle(input string req);
    check(aw_en == 1'b0, req, 32'(aw_en), 32'd0);
    check(pre_req == 4'h0, req, 32'(pre_req), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    open_row = {row_of(2'd3), row_of(2'd2), row_of(2'd1), row_of(2'd0)};
    rst_n = 1'b0;
    cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    a = '0; ba = '0; dq = '0; bl_sel = '0;
    repeat (3) @(negedge clk);
    expect_idle("R11 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_idle("R11 after release");

    // Vector walk: each entry drives one cycle; its result is sampled a cycle later
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        if (VEC[i-1].en) begin
          expect_beat("R1 R2 R5 R6 R7 table", VEC[i-1].ebk, VEC[i-1].ecol,
                      VEC[i-1].edat, VEC[i-1].epre);
        end else begin
          expect_idle("R4 R8 table");
        end
      end
      if (i < NV) begin
        if (VEC[i].wr) drive_wr(VEC[i].ap, VEC[i].bk, VEC[i].col, VEC[i].dq, VEC[i].bl);
        else           drive_nop(VEC[i].dq);
      end
      @(negedge clk);
    end

    // R9: cke low freezes the burst and hides a WRITE on the pins
    drive_wr(1'b1, 2'd0, 10'd0, 16'h3000, 3'd2);
    @(negedge clk);
    expect_beat("R9 start", 2'd0, 10'd0, 16'h3000, 4'h0);
    drive_wr(1'b0, 2'd3, 10'd50, 16'h3BAD, 3'd0);
    cke = 1'b0;
    @(negedge clk);
    expect_idle("R9 cke low 1");
    @(negedge clk);
    expect_idle("R9 cke low 2");
    drive_nop(16'h3001);
    @(negedge clk);
    expect_beat("R9 resume", 2'd0, 10'd1, 16'h3001, 4'h0);
    drive_nop(16'h3002);
    @(negedge clk);
    expect_beat("R9 beat 3", 2'd0, 10'd2, 16'h3002, 4'h0);
    drive_nop(16'h3003);
    @(negedge clk);
    expect_beat("R9 R7 last", 2'd0, 10'd3, 16'h3003, 4'h1);
    drive_nop(16'h3004);
    @(negedge clk);
    expect_idle("R4 after resumed burst");

    // R10: other command states neither stop nor start a burst
    drive_wr(1'b0, 2'd1, 10'd10, 16'h4000, 3'd1);
    @(negedge clk);
    expect_beat("R10 start", 2'd1, 10'd10, 16'h4000, 4'h0);
    drive_nop(16'h4001);
    we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    expect_beat("R10 other cmd no stop", 2'd1, 10'd11, 16'h4001, 4'h0);
    drive_wr(1'b1, 2'd2, 10'd40, 16'h4BAD, 3'd0);
    cs_n = 1'b1;
    @(negedge clk);
    expect_idle("R10 deselected write ignored");
    drive_nop(16'h0000);
    ras_n = 1'b0;
    @(negedge clk);
    expect_idle("R10 other cmd no start");

    // R3: reserved code behaves as one beat
    drive_wr(1'b1, 2'd3, 10'd77, 16'h5000, 3'd5);
    @(negedge clk);
    expect_beat("R3 reserved code", 2'd3, 10'd77, 16'h5000, 4'h8);
    drive_nop(16'h5001);
    @(negedge clk);
    expect_idle("R3 R4 single beat end");

    // R11: reset during a full-page burst
    drive_wr(1'b0, 2'd1, 10'd200, 16'h6000, 3'd7);
    @(negedge clk);
    expect_beat("R5 start", 2'd1, 10'd200, 16'h6000, 4'h0);
    drive_nop(16'h6001);
    rst_n = 1'b0;
    @(negedge clk);
    expect_idle("R11 mid-burst reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_idle("R11 no burst after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule